// File: doc/BRIEF.md
# Packed Byte/Word Media Unit

This block is a purely combinational 64-bit helper for a media-style integer datapath. A function code picks one of sixteen operations on two 64-bit operands, A and B, and the 64-bit result appears in the same cycle. The operations are lane-wise minimum and maximum over eight byte lanes or four 16-bit word lanes, in signed and unsigned forms. There is also a sum of absolute byte differences, used for pixel-error metrics. Fixed pack and unpack layouts move bytes between byte lanes and wider lanes, and three bit-count functions cover population count, leading zeros and trailing zeros.

An execution pipeline places the unit between its operand latches and its result latch. Any code outside the sixteen defined codes raises an illegal-operation flag and forces the result to zero, so the surrounding pipeline can raise its own exception. Every result bit that an operation does not define is driven to zero.

Top module: `mpx_media_unit`

## Requirements
- R1: Code 0x38 returns, in each of the 8 byte lanes, the smaller of A and B compared as signed 8-bit values. Code 0x3E returns the larger. Each lane holds the chosen operand's byte unmodified.
- R2: Code 0x39 returns, in each of the 4 word lanes of 16 bits, the smaller of A and B compared as signed values. Code 0x3F returns the larger.
- R3: Code 0x3A returns, in each byte lane, the smaller of A and B compared as unsigned values. Code 0x3C returns the larger.
- R4: Code 0x3B returns, in each 16-bit lane, the smaller of A and B compared as unsigned values. Code 0x3D returns the larger. When two lanes are equal, B's lane is returned; it holds the same value.
- R5: Code 0x31 returns the sum over all 8 byte lanes of the absolute difference between A's byte and B's byte, each taken as unsigned. The sum is zero-extended to 64 bits.
- R6: Code 0x34 copies B bytes 0 to 3 into result bits [7:0], [23:16], [39:32] and [55:48]. Code 0x35 copies B byte 0 into bits [7:0] and B byte 1 into bits [39:32]. All other result bits are zero.
- R7: Code 0x36 places the low byte of each 16-bit lane of B into result bytes 0 to 3. Code 0x37 places B bits [7:0] and [39:32] into result bytes 0 and 1. All other result bits are zero.
- R8: Code 0x30 returns the number of set bits in B.
- R9: Code 0x32 returns the number of zero bits above the highest set bit of B, or 64 when B is zero.
- R10: Code 0x33 returns the number of zero bits below the lowest set bit of B, or 64 when B is zero.
- R11: The results of codes 0x30, 0x32 and 0x33 do not depend on A.
- R12: Any code other than 0x30 to 0x3F, including codes with bit 6 set, drives illegal_op high and the result to zero. Every defined code drives illegal_op low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_code | input | 7 | Operation select code |
| opnd_a | input | 64 | First operand, A |
| opnd_b | input | 64 | Second operand, B |
| result | output | 64 | Operation result |
| illegal_op | output | 1 | High when func_code is not a defined operation |

## Verification
The bench builds the unit with its default parameters: a 64-bit datapath and the binary-halving form of the zero counters (CNT_TREE = 1). These values exercise the full eight-byte and four-word lane sets and the exact pack and unpack layouts. They also cover the 64 result of the zero counters, where every halving level of the counter fires. Directed operands put lanes near the sign boundary, where signed and unsigned ordering disagree, and make lanes equal. A pseudo-random sweep then runs every code, together with undefined codes and codes with the high bit set.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  localparam int MPX_FUNC_W = 7;

  typedef enum logic [MPX_FUNC_W-1:0] {
    OP_POPCNT  = 7'h30,
    OP_SAD     = 7'h31,
    OP_LZCNT   = 7'h32,
    OP_TZCNT   = 7'h33,
    OP_UNPK_BW = 7'h34,
    OP_UNPK_BL = 7'h35,
    OP_PACK_WB = 7'h36,
    OP_PACK_LB = 7'h37,
    OP_MIN_SB  = 7'h38,
    OP_MIN_SW  = 7'h39,
    OP_MIN_UB  = 7'h3A,
    OP_MIN_UW  = 7'h3B,
    OP_MAX_UB  = 7'h3C,
    OP_MAX_UW  = 7'h3D,
    OP_MAX_SB  = 7'h3E,
    OP_MAX_SW  = 7'h3F
  } mpx_op_e;
endpackage

// File: rtl/mpx_lane_minmax.sv
module mpx_lane_minmax #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_signed,
  input  logic              want_max,
  output logic [DATA_W-1:0] y
);
  localparam int NUM_LANES = DATA_W / LANE_W;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb, ly;
    logic a_lt_b, b_lt_a, pick_a;

    assign la = a[g*LANE_W +: LANE_W];
    assign lb = b[g*LANE_W +: LANE_W];

    always_comb begin
      if (is_signed) begin
        a_lt_b = $signed(la) < $signed(lb);
        b_lt_a = $signed(lb) < $signed(la);
      end else begin
        a_lt_b = la < lb;
        b_lt_a = lb < la;
      end
      // ties fall through to B's lane
      pick_a = want_max ? b_lt_a : a_lt_b;
      ly     = pick_a ? la : lb;
    end

    assign y[g*LANE_W +: LANE_W] = ly;

    // R1 (also R2, R3, R4): a lane result is always one of the operand lanes
    always_comb begin
      assert_lane_from_operand_R1: assert (ly == la || ly == lb)
        else $error("lane result is not an operand lane");
    end

    // R3: a maximum never lies below A, a minimum never lies above A
    always_comb begin
      if (want_max) begin
        assert_max_not_below_R3: assert (is_signed ? ($signed(ly) >= $signed(la)) : (ly >= la))
          else $error("max lane below operand A");
      end else begin
        assert_min_not_above_R3: assert (is_signed ? ($signed(ly) <= $signed(la)) : (ly <= la))
          else $error("min lane above operand A");
      end
    end
  end
endmodule

// File: rtl/mpx_byte_sad.sv
module mpx_byte_sad #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum
);
  localparam int NUM_BYTES = DATA_W / 8;
  localparam int SUM_W     = 8 + $clog2(NUM_BYTES);

  logic [7:0]       diff [NUM_BYTES];
  logic [SUM_W-1:0] acc;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_diff
    logic [7:0] xa, xb;
    assign xa = a[g*8 +: 8];
    assign xb = b[g*8 +: 8];
    assign diff[g] = (xa >= xb) ? (xa - xb) : (xb - xa);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      acc = acc + SUM_W'(diff[i]);
    end
  end

  assign sum = {{(DATA_W-SUM_W){1'b0}}, acc};

  // R5: the difference sum is zero exactly when the operands match
  always_comb begin
    assert_sad_zero_iff_equal_R5: assert ((sum == '0) == (a == b))
      else $error("SAD zero/equality mismatch");
  end
endmodule

// File: rtl/mpx_bit_count.sv
module mpx_bit_count #(
  parameter int DATA_W   = 64,
  parameter bit CNT_TREE = 1'b1,
  localparam int CNT_W   = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] b,
  output logic [CNT_W-1:0]  pop_cnt,
  output logic [CNT_W-1:0]  lead_cnt,
  output logic [CNT_W-1:0]  trail_cnt
);
  localparam int LEVELS = $clog2(DATA_W);

  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pop_cnt = pop_cnt + CNT_W'(b[i]);
    end
  end

  if (CNT_TREE) begin : g_tree
    logic [DATA_W-1:0] tl, tt;
    always_comb begin
      tl       = b;
      lead_cnt = '0;
      for (int k = 0; k < LEVELS; k++) begin
        if ((tl >> (DATA_W - (DATA_W >> (k + 1)))) == '0) begin
          lead_cnt = lead_cnt + CNT_W'(DATA_W >> (k + 1));
          tl       = tl << (DATA_W >> (k + 1));
        end
      end
      if (!tl[DATA_W-1]) lead_cnt = lead_cnt + CNT_W'(1);
    end
    always_comb begin
      tt        = b;
      trail_cnt = '0;
      for (int k = 0; k < LEVELS; k++) begin
        if ((tt << (DATA_W - (DATA_W >> (k + 1)))) == '0) begin
          trail_cnt = trail_cnt + CNT_W'(DATA_W >> (k + 1));
          tt        = tt >> (DATA_W >> (k + 1));
        end
      end
      if (!tt[0]) trail_cnt = trail_cnt + CNT_W'(1);
    end
  end else begin : g_scan
    always_comb begin
      lead_cnt = CNT_W'(DATA_W);
      for (int i = 0; i < DATA_W; i++) begin
        if (b[i]) lead_cnt = CNT_W'(DATA_W - 1 - i);
      end
    end
    always_comb begin
      trail_cnt = CNT_W'(DATA_W);
      for (int i = DATA_W - 1; i >= 0; i--) begin
        if (b[i]) trail_cnt = CNT_W'(i);
      end
    end
  end

  // R9: the full-width leading count appears exactly for a zero operand
  always_comb begin
    assert_lead_full_iff_zero_R9: assert ((lead_cnt == CNT_W'(DATA_W)) == (b == '0))
      else $error("leading count / zero mismatch");
  end
  // R10: the same holds for the trailing count
  always_comb begin
    assert_trail_full_iff_zero_R10: assert ((trail_cnt == CNT_W'(DATA_W)) == (b == '0))
      else $error("trailing count / zero mismatch");
  end
  // R8: all bits set leaves no zero bits to count at either end
  always_comb begin
    if (pop_cnt == CNT_W'(DATA_W)) begin
      assert_full_pop_no_zeros_R8: assert (lead_cnt == '0 && trail_cnt == '0)
        else $error("full population with zero count");
    end
  end
endmodule

// File: rtl/mpx_media_unit.sv
module mpx_media_unit
  import mpx_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter bit CNT_TREE = 1'b1
) (
  input  logic [MPX_FUNC_W-1:0] func_code,
  input  logic [DATA_W-1:0]     opnd_a,
  input  logic [DATA_W-1:0]     opnd_b,
  output logic [DATA_W-1:0]     result,
  output logic                  illegal_op
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam int N_W16 = DATA_W / 16;
  localparam int N_W32 = DATA_W / 32;

  logic              mm_signed_b, mm_max_b, mm_signed_w, mm_max_w;
  logic [DATA_W-1:0] mm_byte, mm_word, sad_sum;
  logic [DATA_W-1:0] unpk_bw, unpk_bl, pack_wb, pack_lb;
  logic [CNT_W-1:0]  pop_cnt, lead_cnt, trail_cnt;

  always_comb begin
    mm_signed_b = (func_code == OP_MIN_SB) || (func_code == OP_MAX_SB);
    mm_max_b    = (func_code == OP_MAX_UB) || (func_code == OP_MAX_SB);
    mm_signed_w = (func_code == OP_MIN_SW) || (func_code == OP_MAX_SW);
    mm_max_w    = (func_code == OP_MAX_UW) || (func_code == OP_MAX_SW);
  end

  mpx_lane_minmax #(.DATA_W(DATA_W), .LANE_W(8)) u_mm_byte (
    .a(opnd_a), .b(opnd_b), .is_signed(mm_signed_b), .want_max(mm_max_b), .y(mm_byte)
  );

  mpx_lane_minmax #(.DATA_W(DATA_W), .LANE_W(16)) u_mm_word (
    .a(opnd_a), .b(opnd_b), .is_signed(mm_signed_w), .want_max(mm_max_w), .y(mm_word)
  );

  mpx_byte_sad #(.DATA_W(DATA_W)) u_sad (
    .a(opnd_a), .b(opnd_b), .sum(sad_sum)
  );

  mpx_bit_count #(.DATA_W(DATA_W), .CNT_TREE(CNT_TREE)) u_cnt (
    .b(opnd_b), .pop_cnt(pop_cnt), .lead_cnt(lead_cnt), .trail_cnt(trail_cnt)
  );

  // byte <-> wider lane movement
  always_comb begin
    unpk_bw = '0;
    unpk_bl = '0;
    pack_wb = '0;
    pack_lb = '0;
    for (int i = 0; i < N_W16; i++) begin
      unpk_bw[i*16 +: 8] = opnd_b[i*8 +: 8];
      pack_wb[i*8 +: 8]  = opnd_b[i*16 +: 8];
    end
    for (int i = 0; i < N_W32; i++) begin
      unpk_bl[i*32 +: 8] = opnd_b[i*8 +: 8];
      pack_lb[i*8 +: 8]  = opnd_b[i*32 +: 8];
    end
  end

  always_comb begin
    illegal_op = 1'b0;
    result     = '0;
    case (func_code)
      OP_POPCNT:  result = {{(DATA_W-CNT_W){1'b0}}, pop_cnt};
      OP_SAD:     result = sad_sum;
      OP_LZCNT:   result = {{(DATA_W-CNT_W){1'b0}}, lead_cnt};
      OP_TZCNT:   result = {{(DATA_W-CNT_W){1'b0}}, trail_cnt};
      OP_UNPK_BW: result = unpk_bw;
      OP_UNPK_BL: result = unpk_bl;
      OP_PACK_WB: result = pack_wb;
      OP_PACK_LB: result = pack_lb;
      OP_MIN_SB, OP_MIN_UB, OP_MAX_UB, OP_MAX_SB: result = mm_byte;
      OP_MIN_SW, OP_MIN_UW, OP_MAX_UW, OP_MAX_SW: result = mm_word;
      default:    illegal_op = 1'b1;
    endcase
  end

  // R12: a flagged code leaves nothing on the result bus
  always_comb begin
    if (illegal_op) begin
      assert_illegal_zero_result_R12: assert (result == '0)
        else $error("illegal code with non-zero result");
    end
  end
  // R12: codes with the top bit set are never accepted
  always_comb begin
    if (func_code[MPX_FUNC_W-1]) begin
      assert_high_code_illegal_R12: assert (illegal_op)
        else $error("high code accepted");
    end
  end
  // R6: unpacked results never set bits above the byte of each lane
  always_comb begin
    if (func_code == OP_UNPK_BW) begin
      assert_unpack_clean_R6: assert ((result & ~{N_W16{16'h00FF}}) == '0)
        else $error("unpack set a pad bit");
    end
  end
endmodule

// File: tb/mpx_media_unit_bench.sv
module mpx_media_unit_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [6:0]  func_code;
  logic [63:0] opnd_a, opnd_b, result;
  logic        illegal_op;
  exp_t        sb_q[$];
  int          n_checks, n_errors;
  bit          done;

  mpx_media_unit u_mpx_media_unit (
    .func_code(func_code), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .illegal_op(illegal_op)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] model(input logic [6:0] c, input logic [63:0] a,
                                        input logic [63:0] b, output logic ill);
    logic [63:0] r, x, y, xs, ys, msk, sel, sgn;
    int          w;
    logic        is_s, is_max;
    r = '0;
    ill = 1'b0;
    case (c)
      7'h30: r = 64'($countones(b));
      7'h31: for (int i = 0; i < 8; i++) begin
               x = 64'(a[8*i +: 8]); y = 64'(b[8*i +: 8]);
               r = r + ((x > y) ? x - y : y - x);
             end
      7'h32: begin r = 64; for (int i = 0; i < 64; i++) if (b[i]) r = 64'(63 - i); end
      7'h33: begin r = 64; for (int i = 63; i >= 0; i--) if (b[i]) r = 64'(i); end
      7'h34: for (int i = 0; i < 4; i++) r[16*i +: 8] = b[8*i +: 8];
      7'h35: for (int i = 0; i < 2; i++) r[32*i +: 8] = b[8*i +: 8];
      7'h36: for (int i = 0; i < 4; i++) r[8*i +: 8] = b[16*i +: 8];
      7'h37: for (int i = 0; i < 2; i++) r[8*i +: 8] = b[32*i +: 8];
      7'h38, 7'h39, 7'h3A, 7'h3B, 7'h3C, 7'h3D, 7'h3E, 7'h3F: begin
        w      = c[0] ? 16 : 8;
        msk    = c[0] ? 64'hFFFF : 64'hFF;
        sgn    = c[0] ? 64'h8000 : 64'h80;
        is_s   = (c == 7'h38) || (c == 7'h39) || (c == 7'h3E) || (c == 7'h3F);
        is_max = c[2];
        for (int i = 0; i < 64 / w; i++) begin
          x  = (a >> (i * w)) & msk;
          y  = (b >> (i * w)) & msk;
          xs = is_s ? (x ^ sgn) : x;
          ys = is_s ? (y ^ sgn) : y;
          sel = is_max ? ((xs > ys) ? x : y) : ((xs < ys) ? x : y);
          r = r | (sel << (i * w));
        end
      end
      default: ill = 1'b1;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [6:0] c);
    case (c)
      7'h38, 7'h3E: return "R1";
      7'h39, 7'h3F: return "R2";
      7'h3A, 7'h3C: return "R3";
      7'h3B, 7'h3D: return "R4";
      7'h31: return "R5";
      7'h34, 7'h35: return "R6";
      7'h36, 7'h37: return "R7";
      7'h30: return "R8";
      7'h32: return "R9";
      7'h33: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic drive(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b,
                       input string tag);
    exp_t e;
    @(negedge clk);
    func_code = c;
    opnd_a    = a;
    opnd_b    = b;
    e.res = model(c, a, b, e.ill);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: one scoreboard item per rising edge, half a period after the drive
  always @(posedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_checks++;
      if (result !== e.res || illegal_op !== e.ill) begin
        n_errors++;
        $display("FAIL %s: code=%h result=%h ill=%b expected result=%h ill=%b",
                 e.tag, func_code, result, illegal_op, e.res, e.ill);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] va, vb, lf;
    n_checks = 0;
    n_errors = 0;
    done = 1'b0;
    rst_n = 1'b0;
    func_code = '0;
    opnd_a = '0;
    opnd_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // idle/reset state: code 0 with zero operands is illegal and zero
    drive(7'h00, 64'h0, 64'h0, "R12");

    // sign-boundary lanes where signed and unsigned orders disagree
    va = 64'h807F_01FF_0010_FE05;
    vb = 64'h7F80_FF01_0020_05FE;
    drive(7'h38, va, vb, "R1");
    drive(7'h3E, va, vb, "R1");
    drive(7'h39, va, vb, "R2");
    drive(7'h3F, va, vb, "R2");
    drive(7'h3A, va, vb, "R3");
    drive(7'h3C, va, vb, "R3");
    drive(7'h3B, va, vb, "R4");
    drive(7'h3D, va, vb, "R4");
    // equal lanes
    drive(7'h38, vb, vb, "R1");
    drive(7'h3D, va, va, "R4");

    drive(7'h31, va, vb, "R5");
    drive(7'h31, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R5");
    drive(7'h31, va, va, "R5");

    drive(7'h34, 64'h0, 64'h8877_6655_4433_2211, "R6");
    drive(7'h35, 64'h0, 64'h8877_6655_4433_2211, "R6");
    drive(7'h36, 64'h0, 64'h8877_6655_4433_2211, "R7");
    drive(7'h37, 64'h0, 64'h8877_6655_4433_2211, "R7");

    drive(7'h30, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    drive(7'h30, 64'h0, 64'h0, "R8");
    drive(7'h32, 64'h0, 64'h0, "R9");
    drive(7'h32, 64'h0, 64'h1, "R9");
    drive(7'h32, 64'h0, 64'h8000_0000_0000_0000, "R9");
    drive(7'h32, 64'h0, 64'h0000_0000_0001_0000, "R9");
    drive(7'h33, 64'h0, 64'h0, "R10");
    drive(7'h33, 64'h0, 64'h8000_0000_0000_0000, "R10");
    drive(7'h33, 64'h0, 64'h1, "R10");
    drive(7'h33, 64'h0, 64'h0000_0100_0000_0000, "R10");

    // R11: B fixed, A changed; expectation ignores A entirely
    drive(7'h30, 64'h0, 64'h00F0_0000_0300_0000, "R11");
    drive(7'h30, 64'hFFFF_FFFF_FFFF_FFFF, 64'h00F0_0000_0300_0000, "R11");
    drive(7'h32, 64'hDEAD_BEEF_0123_4567, 64'h00F0_0000_0300_0000, "R11");
    drive(7'h33, 64'hDEAD_BEEF_0123_4567, 64'h00F0_0000_0300_0000, "R11");

    drive(7'h2F, va, vb, "R12");
    drive(7'h40, va, vb, "R12");
    drive(7'h70, va, vb, "R12");
    drive(7'h7F, va, vb, "R12");

    // pseudo-random sweep across every code and neighbours
    lf = 64'h1234_5678_9ABC_DEF1;
    for (int it = 0; it < 40; it++) begin
      for (int c = 8'h2E; c <= 8'h41; c++) begin
        va = lf;
        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
        vb = lf ^ {lf[31:0], lf[63:32]};
        lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
        drive(7'(c), va, vb, tag_of(7'(c)));
      end
    end

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule